// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides which hardware thread the instruction fetch stage serves in a given cycle. Each cycle it looks at every thread's fetch state code and at a mask of the threads that are currently active. It returns up to `FETCH_SLOTS` selections, each made of a thread index and a valid bit. A fetch stage that serves several threads per cycle uses the slots in order. The first slot that comes back without a valid thread ends that cycle's selections.

The `policy` input picks one of two modes. In round-robin mode the block keeps an ordered list of thread IDs in registers. It scans the list from the front and takes the first thread that can fetch. When the cycle's selections are consumed (`sel_req` high), each thread that was taken moves to the back of the list. In single-thread mode only the lowest-numbered active thread is considered. A pending drain suppresses every selection. A thread count outside 1..`MAX_THREADS` stops elaboration with an error message. With one thread, the block always behaves as in single-thread mode.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread may be selected only when its active bit is set and its 3-bit state code is 0 (running), 1 (idle) or 6 (line returned). The other codes are 2 (squashing), 3 (blocked), 4 (retry wait), 5 (response wait) and 7 (trap wait), and a thread in any of them is never selected.
- R2: With `policy`=1 (round-robin), a slot selects the first eligible thread found when the list is scanned from its front.
- R3: A consumed round-robin selection removes the selected thread from its list position and appends it at the back, keeping the order of the others. The list changes only on a clock edge where `sel_req` is 1 and slot 0 is valid.
- R4: After reset the list holds the thread IDs 0, 1, ..., N-1 from front to back.
- R5: When a slot has no eligible thread, its valid bit is 0 and its index reads 0.
- R6: With `policy`=0 (single-thread), only the lowest-numbered active thread is examined. Every slot returns that thread if it is eligible, and no thread otherwise. The list stays unchanged.
- R7: Slot k sees the list as already reordered by the valid selections of slots 0..k-1. If a slot is not valid, every later slot is not valid.
- R8: While `drain_pend` is 1, no slot is valid and the list does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| policy | input | 1 | 0 single-thread, 1 round-robin |
| drain_pend | input | 1 | Drain pending, suppresses selection |
| sel_req | input | 1 | This cycle's selections are consumed |
| active_mask | input | NUM_THREADS | Active-thread mask, bit i for thread i |
| thr_status | input | 3*NUM_THREADS | State code of thread i in bits 3i+2..3i |
| pick_tid | output | FETCH_SLOTS*TW | Selected index of slot k in bits k*TW+TW-1..k*TW |
| pick_vld | output | FETCH_SLOTS | Valid bit of each slot |

## Verification
Several properties are checked on every cycle. A valid slot always names an eligible thread. No slot is valid during a drain, and a slot is valid only if the slot before it is. Invalid slots read index 0. The stored list is always a permutation of the thread IDs, and it moves only on a consumed round-robin selection, which puts the last selected thread at the back. The scan order itself can only be shown by the bench, which replays sequences against an independent list model: the ascending order after reset, fairness across consecutive cycles, skipping of blocked or inactive threads, and single-thread mode leaving the rotation untouched.

// File: rtl/fsel_pkg.sv
`timescale 1ns/1ps
package fsel_pkg;
  localparam int STW = 3;

  typedef enum logic [STW-1:0] {
    TS_RUN     = 3'd0,
    TS_IDLE    = 3'd1,
    TS_SQUASH  = 3'd2,
    TS_BLOCK   = 3'd3,
    TS_RETRY   = 3'd4,
    TS_WAITRSP = 3'd5,
    TS_LINERDY = 3'd6,
    TS_TRAP    = 3'd7
  } thr_state_e;

  typedef enum logic {
    POL_SINGLE = 1'b0,
    POL_RR     = 1'b1
  } fetch_pol_e;

  // a thread may fetch only from these three states
  function automatic logic state_can_fetch(input logic [STW-1:0] s);
    return (s == TS_RUN) || (s == TS_IDLE) || (s == TS_LINERDY);
  endfunction
endpackage

// File: rtl/fsel_elig.sv
`timescale 1ns/1ps
module fsel_elig
  import fsel_pkg::*;
#(
  parameter int NT = 4
) (
  input  logic [NT*STW-1:0] thr_status,
  input  logic [NT-1:0]     active_mask,
  output logic [NT-1:0]     elig
);
  for (genvar i = 0; i < NT; i++) begin : g_thr
    assign elig[i] = active_mask[i] && state_can_fetch(thr_status[i*STW +: STW]);
  end
endmodule

// File: rtl/fsel_first_active.sv
`timescale 1ns/1ps
module fsel_first_active #(
  parameter int NT = 4,
  parameter int TW = 2
) (
  input  logic [NT-1:0] active_mask,
  input  logic [NT-1:0] elig,
  output logic [TW-1:0] tid,
  output logic          vld
);
  logic          any_act;
  logic [TW-1:0] low_tid;

  always_comb begin
    any_act = 1'b0;
    low_tid = '0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (active_mask[i]) begin
        any_act = 1'b1;
        low_tid = TW'(i);
      end
    end
  end

  assign vld = any_act && elig[low_tid];
  assign tid = vld ? low_tid : '0;
endmodule

// File: rtl/fsel_rr_step.sv
`timescale 1ns/1ps
module fsel_rr_step #(
  parameter int NT = 4,
  parameter int TW = 2
) (
  input  logic [NT*TW-1:0] ord_in,
  input  logic [NT-1:0]    elig,
  output logic [TW-1:0]    tid,
  output logic             vld,
  output logic [NT*TW-1:0] ord_out
);
  logic          hit;
  int unsigned   hit_pos;
  logic [TW-1:0] hit_tid;

  // scan from the front, first eligible entry wins
  always_comb begin
    hit     = 1'b0;
    hit_pos = 0;
    hit_tid = '0;
    for (int p = 0; p < NT; p++) begin
      if (!hit && elig[ord_in[p*TW +: TW]]) begin
        hit     = 1'b1;
        hit_pos = p;
        hit_tid = ord_in[p*TW +: TW];
      end
    end
  end

  // close the gap at hit_pos and put the winner at the back
  always_comb begin
    for (int p = 0; p < NT; p++) begin
      if (!hit || p < hit_pos) begin
        ord_out[p*TW +: TW] = ord_in[p*TW +: TW];
      end else if (p == NT - 1) begin
        ord_out[p*TW +: TW] = hit_tid;
      end else begin
        ord_out[p*TW +: TW] = ord_in[(p+1)*TW +: TW];
      end
    end
  end

  assign vld = hit;
  assign tid = hit_tid;
endmodule

// File: rtl/fsel_order_reg.sv
`timescale 1ns/1ps
module fsel_order_reg #(
  parameter int NT = 4,
  parameter int TW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [NT*TW-1:0] ord_nxt,
  output logic [NT*TW-1:0] ord_q
);
  for (genvar i = 0; i < NT; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ord_q[i*TW +: TW] <= TW'(i);
      end else if (upd) begin
        ord_q[i*TW +: TW] <= ord_nxt[i*TW +: TW];
      end
    end
  end
endmodule

// File: rtl/fetch_thread_sel.sv
`timescale 1ns/1ps
module fetch_thread_sel
  import fsel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int MAX_THREADS = 4,
  parameter int FETCH_SLOTS = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              policy,
  input  logic                              drain_pend,
  input  logic                              sel_req,
  input  logic [NUM_THREADS-1:0]            active_mask,
  input  logic [NUM_THREADS*3-1:0]          thr_status,
  output logic [FETCH_SLOTS*((NUM_THREADS>1)?$clog2(NUM_THREADS):1)-1:0] pick_tid,
  output logic [FETCH_SLOTS-1:0]            pick_vld
);
  localparam int NT    = NUM_THREADS;
  localparam int TW    = (NT > 1) ? $clog2(NT) : 1;
  localparam int OW    = NT * TW;
  localparam bit RR_OK = (NT > 1);

  if (NUM_THREADS < 1 || NUM_THREADS > MAX_THREADS) begin : g_cfg_bad
    $error("fetch_thread_sel: NUM_THREADS outside 1..MAX_THREADS");
  end

  // named internal events
  logic [NT-1:0]                    elig;
  logic [OW-1:0]                    order_q;
  logic                             rr_mode;
  logic                             order_upd;
  logic [FETCH_SLOTS:0][OW-1:0]     ord_chain;
  logic [TW-1:0]                    one_tid;
  logic                             one_vld;

  assign rr_mode = RR_OK && (policy == POL_RR);

  fsel_elig #(.NT(NT)) u_elig (
    .thr_status (thr_status),
    .active_mask(active_mask),
    .elig       (elig)
  );

  fsel_first_active #(.NT(NT), .TW(TW)) u_first (
    .active_mask(active_mask),
    .elig       (elig),
    .tid        (one_tid),
    .vld        (one_vld)
  );

  assign ord_chain[0] = order_q;

  for (genvar k = 0; k < FETCH_SLOTS; k++) begin : g_slot
    logic [TW-1:0] st_tid;
    logic          st_vld;
    logic [OW-1:0] st_ord;
    logic          gate;

    fsel_rr_step #(.NT(NT), .TW(TW)) u_step (
      .ord_in (ord_chain[k]),
      .elig   (elig),
      .tid    (st_tid),
      .vld    (st_vld),
      .ord_out(st_ord)
    );

    if (k == 0) begin : g_head
      assign gate = !drain_pend;
    end else begin : g_tail
      assign gate = !drain_pend && pick_vld[k-1];
    end

    assign pick_vld[k] = gate && (rr_mode ? st_vld : one_vld);
    assign pick_tid[k*TW +: TW] = !pick_vld[k] ? '0 :
                                  (rr_mode ? st_tid : one_tid);
    assign ord_chain[k+1] = (rr_mode && pick_vld[k]) ? st_ord : ord_chain[k];
  end

  assign order_upd = sel_req && rr_mode && pick_vld[0];

  fsel_order_reg #(.NT(NT), .TW(TW)) u_order (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (order_upd),
    .ord_nxt(ord_chain[FETCH_SLOTS]),
    .ord_q  (order_q)
  );
endmodule

// File: rtl/fsel_chk.sv
`timescale 1ns/1ps
module fsel_chk #(
  parameter int NT = 4,
  parameter int TW = 2,
  parameter int SL = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             policy,
  input logic             drain_pend,
  input logic             sel_req,
  input logic [NT-1:0]    elig,
  input logic [NT*TW-1:0] order_q,
  input logic [SL*TW-1:0] pick_tid,
  input logic [SL-1:0]    pick_vld
);
  logic [NT-1:0] seen;
  logic [TW-1:0] last_tid;

  always_comb begin
    seen = '0;
    for (int p = 0; p < NT; p++) seen[order_q[p*TW +: TW]] = 1'b1;
  end

  always_comb begin
    last_tid = '0;
    for (int k = 0; k < SL; k++) if (pick_vld[k]) last_tid = pick_tid[k*TW +: TW];
  end

  for (genvar k = 0; k < SL; k++) begin : g_slot
    // R1
    pick_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pick_vld[k] |-> elig[pick_tid[k*TW +: TW]]);
    // R5
    idle_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pick_vld[k] |-> pick_tid[k*TW +: TW] == '0);
    if (k > 0) begin : g_chain
      // R7
      slot_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld[k] |-> pick_vld[k-1]);
      // R6
      single_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!policy && pick_vld[k]) |-> pick_tid[k*TW +: TW] == pick_tid[0 +: TW]);
    end
  end

  // R8
  drain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_pend |-> pick_vld == '0);

  // R3
  order_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == NT);

  // R3
  order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_req && policy && pick_vld[0]) |=> $stable(order_q));

  // R3
  order_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_req && policy && pick_vld[0]) |=> order_q[(NT-1)*TW +: TW] == $past(last_tid));
endmodule

bind fetch_thread_sel fsel_chk #(.NT(NT), .TW(TW), .SL(FETCH_SLOTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .policy    (rr_mode),
  .drain_pend(drain_pend),
  .sel_req   (sel_req),
  .elig      (elig),
  .order_q   (order_q),
  .pick_tid  (pick_tid),
  .pick_vld  (pick_vld)
);

// File: tb/sim_fetch_thread_sel.sv
`timescale 1ns/1ps
module sim_fetch_thread_sel;
  localparam int NT = 4;
  localparam int TW = 2;
  localparam int SL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic policy = 1'b0, drain_pend = 1'b0, sel_req = 1'b0;
  logic [NT-1:0]    active_mask = '0;
  logic [NT*3-1:0]  thr_status = '0;
  logic [SL*TW-1:0] pick_tid;
  logic [SL-1:0]    pick_vld;

  always #2 clk = ~clk;

  fetch_thread_sel #(.NUM_THREADS(NT), .MAX_THREADS(4), .FETCH_SLOTS(SL)) u0 (
    .clk(clk), .rst_n(rst_n), .policy(policy), .drain_pend(drain_pend),
    .sel_req(sel_req), .active_mask(active_mask), .thr_status(thr_status),
    .pick_tid(pick_tid), .pick_vld(pick_vld)
  );

  typedef struct {
    logic [SL-1:0]    vld;
    logic [SL*TW-1:0] tid;
    string            tag;
  } exp_t;

  exp_t sbq[$];
  event mon_ev;
  int   total = 0;
  int   bad = 0;
  bit   done = 0;
  int   m_ord[NT];

  // state codes: 0 run, 1 idle, 6 line ready may fetch
  function automatic bit can_go(input logic [NT*3-1:0] st, input logic [NT-1:0] act, input int t);
    logic [2:0] c;
    c = st[t*3 +: 3];
    return act[t] && (c == 3'd0 || c == 3'd1 || c == 3'd6);
  endfunction

  function automatic logic [NT*3-1:0] mk_st(input int a, input int b, input int c, input int d);
    return {3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  // monitor: pops the scoreboard and compares with the outputs
  initial begin
    forever begin
      @(mon_ev);
      while (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        total++;
        if (pick_vld !== e.vld || pick_tid !== e.tid) begin
          bad++;
          $display("FAIL %s: vld=%b tid=%h expected vld=%b tid=%h",
                   e.tag, pick_vld, pick_tid, e.vld, e.tid);
        end
      end
    end
  end

  // driver: sets inputs, predicts, pushes, then advances the list model
  task automatic drive(input logic pol, input logic drn, input logic req,
                       input logic [NT-1:0] act, input logic [NT*3-1:0] st,
                       input string tag);
    exp_t e;
    int   o[NT];
    bit   prev;
    @(negedge clk);
    policy = pol; drain_pend = drn; sel_req = req;
    active_mask = act; thr_status = st;
    foreach (o[i]) o[i] = m_ord[i];
    e.vld = '0; e.tid = '0; e.tag = tag;
    prev = 1'b1;
    for (int k = 0; k < SL; k++) begin
      if (drn || !prev) begin
        prev = 1'b0;
      end else if (pol) begin
        int pos = -1;
        for (int p = 0; p < NT; p++) if (pos < 0 && can_go(st, act, o[p])) pos = p;
        if (pos >= 0) begin
          int w = o[pos];
          for (int p = pos; p < NT - 1; p++) o[p] = o[p+1];
          o[NT-1] = w;
          e.vld[k] = 1'b1;
          e.tid[k*TW +: TW] = TW'(w);
        end else prev = 1'b0;
      end else begin
        int f = -1;
        for (int t = NT - 1; t >= 0; t--) if (act[t]) f = t;
        if (f >= 0 && can_go(st, act, f)) begin
          e.vld[k] = 1'b1;
          e.tid[k*TW +: TW] = TW'(f);
        end else prev = 1'b0;
      end
    end
    sbq.push_back(e);
    #1 ->mon_ev;
    #0;
    if (req && pol && e.vld[0]) foreach (o[i]) m_ord[i] = o[i];
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    foreach (m_ord[i]) m_ord[i] = i;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R4: ascending order right after reset, no consumption
    drive(1, 0, 0, 4'b1111, mk_st(0,0,0,0), "R4 reset order");
    drive(1, 0, 0, 4'b1111, mk_st(0,0,0,0), "R4 R3 no req keeps order");
    // R2 R3: rotation across cycles
    drive(1, 0, 1, 4'b1111, mk_st(0,1,6,0), "R2 R3 rotate a");
    drive(1, 0, 1, 4'b1111, mk_st(0,0,0,0), "R2 R3 rotate b");
    drive(1, 0, 1, 4'b1111, mk_st(0,0,0,0), "R2 R3 rotate c");
    // R1: blocked, squashing, waiting states skipped
    drive(1, 0, 1, 4'b1111, mk_st(3,2,0,5), "R1 skip non-fetch states");
    drive(1, 0, 1, 4'b1111, mk_st(4,7,6,1), "R1 skip retry and trap");
    // R1: inactive thread skipped
    drive(1, 0, 1, 4'b1011, mk_st(0,0,0,0), "R1 inactive skipped");
    // R7: single eligible thread taken by both slots
    drive(1, 0, 1, 4'b1111, mk_st(3,3,0,3), "R7 one eligible twice");
    // R5 R7: nobody eligible
    drive(1, 0, 1, 4'b1111, mk_st(2,3,4,5), "R5 none eligible");
    drive(1, 0, 1, 4'b0000, mk_st(0,0,0,0), "R5 none active");
    // R8: drain suppresses and keeps order
    drive(1, 1, 1, 4'b1111, mk_st(0,0,0,0), "R8 drain");
    drive(1, 0, 0, 4'b1111, mk_st(0,0,0,0), "R8 order after drain");
    // R6: single mode
    drive(0, 0, 1, 4'b1100, mk_st(3,3,0,0), "R6 lowest active picked");
    drive(0, 0, 1, 4'b1100, mk_st(0,0,3,0), "R6 lowest active blocked");
    drive(0, 0, 1, 4'b1111, mk_st(6,0,0,0), "R6 thread0 line ready");
    drive(1, 0, 0, 4'b1111, mk_st(0,0,0,0), "R6 order untouched");
    // broad mix of inputs
    for (int n = 0; n < 400; n++) begin
      logic [NT*3-1:0] st;
      st = NT*3'($urandom);
      drive(1'($urandom), ($urandom % 8) == 0, 1'($urandom), NT'($urandom), st,
            "R1 R2 R3 R6 R7 R8 mix");
    end
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule